// File: doc/BRIEF.md
# Iterative Signed Word Multiplier with Destination Interlock

This unit sits beside a simple integer pipeline and runs the three-register multiply that writes a general-purpose register. When the pipeline offers an instruction word with its two source values, the unit checks the encoding. If the word is the multiply, the unit takes both sources as signed 32-bit numbers and starts a radix-4 Booth iteration. The unit keeps only the low 32 bits of the 64-bit product and returns them sign-extended to the register width. It never flags overflow or raises an exception.

While the multiply runs, the pipeline keeps executing other instructions. The unit records the destination index as a pending tag. It raises `stall` whenever a read-port address of a later instruction matches that tag. Latency depends on the data: the iteration stops as soon as the multiplier bits still to be consumed are all copies of its sign, so a short second operand finishes early. The result leaves through a one-cycle writeback pulse. In a 64-bit build, a source that is not a sign-extended word raises a flag beside the result, and that result carries no meaning.

Top module: `imul_unit`

## Requirements
- R1: A word is accepted as the multiply only when bits 31..26 = 011100, bits 10..6 = 00000 and bits 5..0 = 000010. The destination index is bits 15..11. Any other word with `issue_valid` high starts nothing and produces no writeback.
- R2: `wb_data` equals the low 32 bits of the signed product of `issue_rs_val[31:0]` and `issue_rt_val[31:0]`, sign-extended to XLEN. The value wraps silently on overflow.
- R3: After the issue edge, `busy` stays high for exactly n cycles. n is the smallest k in 1..16 such that bits 31..(2k-1) of the second operand are all equal. `wb_valid` rises in the first cycle in which `busy` is low again.
- R4: `wb_valid` is a single-cycle pulse, and `wb_rd` carries the destination index of the finished multiply.
- R5: `issue_ready` is low while `busy` is high. A multiply offered during that time is dropped and does not change the running result, its destination or its tag.
- R6: While `busy` is high, `pending_rd` holds the destination index; it is 0 when idle. `stall` is high exactly when `busy` is high, `pending_rd` is nonzero, and `rd_addr_a` or `rd_addr_b` equals `pending_rd`.
- R7: A multiply whose destination is register 0 still runs for its latency, but it never raises `stall` and never pulses `wb_valid`.
- R8: A synchronous active-high `rst` leaves `busy`, `pending_rd`, `stall` and `wb_valid` low and `issue_ready` high. It also abandons any multiply in flight without a writeback.
- R9: With XLEN = 64, `wb_undef` is high alongside `wb_valid` when bits 63..31 of either source are not all equal, and low otherwise. With XLEN = 32 it is always low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| issue_valid | input | 1 | Instruction word and sources are offered |
| issue_ready | output | 1 | Unit can accept a multiply |
| issue_instr | input | 32 | Instruction word to decode |
| issue_rs_val | input | XLEN | First source value |
| issue_rt_val | input | XLEN | Second source value, sets the latency |
| rd_addr_a | input | 5 | First read-port index of a later instruction |
| rd_addr_b | input | 5 | Second read-port index of a later instruction |
| busy | output | 1 | Multiply in progress |
| pending_rd | output | 5 | Destination awaiting writeback, 0 when idle |
| stall | output | 1 | Read-after-write interlock request |
| wb_valid | output | 1 | One-cycle writeback strobe |
| wb_rd | output | 5 | Writeback destination index |
| wb_data | output | XLEN | Sign-extended low product word |
| wb_undef | output | 1 | Sources were not sign-extended words (64-bit build) |

## Verification
The hardest situation to reach from the ports is a second multiply offered while the first is still iterating. The refusal only shows if the first operation runs long enough and the second carries a different destination and different operands. The stimulus uses a multiplier of 0x40000000, which forces all 16 steps. During those steps it holds a competing multiply on the issue port and probes both read ports against matching and non-matching indices. It then checks that exactly one writeback appears, with the first multiply's tag and product. The 16-step case is also the one used to abandon a multiply with a reset.

// File: rtl/imul_pkg.sv
package imul_pkg;

  localparam int WORD_W    = 32;
  localparam int REG_IDX_W = 5;

  localparam logic [5:0] OPC_MULGRP = 6'b011100;
  localparam logic [4:0] SHAMT_ZERO = 5'b00000;
  localparam logic [5:0] FN_MULWORD = 6'b000010;

  typedef logic [REG_IDX_W-1:0] reg_idx_t;

  typedef struct packed {
    logic     hit;
    reg_idx_t rd;
  } mul_dec_t;

  typedef enum logic [2:0] {
    PP_ZERO = 3'd0,
    PP_POS1 = 3'd1,
    PP_POS2 = 3'd2,
    PP_NEG1 = 3'd3,
    PP_NEG2 = 3'd4
  } booth_sel_e;

  // Radix-4 recoding of a multiplier triplet {b(2i+1), b(2i), b(2i-1)}
  function automatic booth_sel_e booth_sel(input logic [2:0] trip);
    case (trip)
      3'b001, 3'b010: booth_sel = PP_POS1;
      3'b011:         booth_sel = PP_POS2;
      3'b100:         booth_sel = PP_NEG2;
      3'b101, 3'b110: booth_sel = PP_NEG1;
      default:        booth_sel = PP_ZERO;
    endcase
  endfunction

endpackage

// File: rtl/imul_decode.sv
module imul_decode
  import imul_pkg::*;
(
  input  logic [5:0] opcode,
  input  logic [4:0] shamt,
  input  logic [5:0] funct,
  input  reg_idx_t   rd_field,
  output mul_dec_t   dec
);

  always_comb begin
    dec.hit = (opcode == OPC_MULGRP) && (shamt == SHAMT_ZERO) && (funct == FN_MULWORD);
    dec.rd  = rd_field;
  end

endmodule

// File: rtl/imul_booth_core.sv
module imul_booth_core #(
  parameter int WORD = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start,
  input  logic [WORD-1:0] mcand,
  input  logic [WORD-1:0] mplier,
  output logic            busy,
  output logic            last_step,
  output logic [WORD-1:0] prod_next
);
  import imul_pkg::*;

  localparam int DIGITS = WORD / 2;
  localparam int CNT_W  = $clog2(DIGITS);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DIGITS - 1);

  logic [WORD-1:0]  acc_q;
  logic [WORD-1:0]  mc_q;
  logic [WORD:0]    mq_q;
  logic [CNT_W-1:0] cnt_q;
  logic             busy_q;

  booth_sel_e       sel;
  logic [WORD-1:0]  pp;
  logic [WORD:0]    mq_shift;
  logic             rest_is_sign;

  always_comb begin
    sel = booth_sel(mq_q[2:0]);
    case (sel)
      PP_POS1: pp = mc_q;
      PP_POS2: pp = mc_q << 1;
      PP_NEG1: pp = -mc_q;
      PP_NEG2: pp = -(mc_q << 1);
      default: pp = '0;
    endcase
    mq_shift     = $signed(mq_q) >>> 2;
    rest_is_sign = (&mq_shift) | (~|mq_shift);
  end

  assign prod_next = acc_q + pp;
  assign last_step = busy_q && (rest_is_sign || (cnt_q == CNT_LAST));
  assign busy      = busy_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      acc_q  <= '0;
      mc_q   <= '0;
      mq_q   <= '0;
      cnt_q  <= '0;
    end else if (start && !busy_q) begin
      busy_q <= 1'b1;
      acc_q  <= '0;
      mc_q   <= mcand;
      mq_q   <= {mplier, 1'b0};
      cnt_q  <= '0;
    end else if (busy_q) begin
      acc_q  <= prod_next;
      mc_q   <= mc_q << 2;
      mq_q   <= mq_shift;
      cnt_q  <= cnt_q + 1'b1;
      if (last_step) busy_q <= 1'b0;
    end
  end

endmodule

// File: rtl/imul_hazard.sv
module imul_hazard #(
  parameter int REG_W = 5,
  parameter int PORTS = 2
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       start,
  input  logic [REG_W-1:0]           start_rd,
  input  logic                       finish,
  input  logic                       busy,
  input  logic [PORTS-1:0][REG_W-1:0] rd_addrs,
  output logic [REG_W-1:0]           tag,
  output logic                       stall
);

  logic [REG_W-1:0] tag_q;
  logic [PORTS-1:0] hit;

  always_ff @(posedge clk) begin
    if (rst)         tag_q <= '0;
    else if (start)  tag_q <= start_rd;
    else if (finish) tag_q <= '0;
  end

  for (genvar p = 0; p < PORTS; p++) begin : g_port
    assign hit[p] = (rd_addrs[p] == tag_q);
  end

  assign tag   = tag_q;
  assign stall = busy && (tag_q != '0) && (|hit);

endmodule

// File: rtl/imul_unit.sv
module imul_unit #(
  parameter int XLEN = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            issue_valid,
  output logic            issue_ready,
  input  logic [31:0]     issue_instr,
  input  logic [XLEN-1:0] issue_rs_val,
  input  logic [XLEN-1:0] issue_rt_val,
  input  logic [4:0]      rd_addr_a,
  input  logic [4:0]      rd_addr_b,
  output logic            busy,
  output logic [4:0]      pending_rd,
  output logic            stall,
  output logic            wb_valid,
  output logic [4:0]      wb_rd,
  output logic [XLEN-1:0] wb_data,
  output logic            wb_undef
);
  import imul_pkg::*;

  mul_dec_t              dec;
  logic                  core_busy;
  logic                  last_step;
  logic [WORD_W-1:0]     prod_next;
  logic                  fire;
  logic [1:0][4:0]       rd_addrs;
  reg_idx_t              tag;
  logic                  rs_bad, rt_bad;
  logic                  undef_q;
  logic [XLEN-1:0]       wb_ext;

  logic                  wb_valid_q;
  reg_idx_t              wb_rd_q;
  logic [XLEN-1:0]       wb_data_q;
  logic                  wb_undef_q;

  imul_decode u_dec (
    .opcode   (issue_instr[31:26]),
    .shamt    (issue_instr[10:6]),
    .funct    (issue_instr[5:0]),
    .rd_field (issue_instr[15:11]),
    .dec      (dec)
  );

  assign fire = issue_valid && dec.hit && !core_busy;

  imul_booth_core #(.WORD(WORD_W)) u_core (
    .clk       (clk),
    .rst       (rst),
    .start     (fire),
    .mcand     (issue_rs_val[WORD_W-1:0]),
    .mplier    (issue_rt_val[WORD_W-1:0]),
    .busy      (core_busy),
    .last_step (last_step),
    .prod_next (prod_next)
  );

  assign rd_addrs = {rd_addr_b, rd_addr_a};

  imul_hazard #(.REG_W(REG_IDX_W), .PORTS(2)) u_haz (
    .clk      (clk),
    .rst      (rst),
    .start    (fire),
    .start_rd (dec.rd),
    .finish   (last_step),
    .busy     (core_busy),
    .rd_addrs (rd_addrs),
    .tag      (tag),
    .stall    (stall)
  );

  if (XLEN > WORD_W) begin : g_wide
    assign rs_bad = !((&issue_rs_val[XLEN-1:WORD_W-1]) || (~|issue_rs_val[XLEN-1:WORD_W-1]));
    assign rt_bad = !((&issue_rt_val[XLEN-1:WORD_W-1]) || (~|issue_rt_val[XLEN-1:WORD_W-1]));
    assign wb_ext = {{(XLEN-WORD_W){prod_next[WORD_W-1]}}, prod_next};
  end else begin : g_word
    assign rs_bad = 1'b0;
    assign rt_bad = 1'b0;
    assign wb_ext = prod_next;
  end

  always_ff @(posedge clk) begin
    if (rst)       undef_q <= 1'b0;
    else if (fire) undef_q <= rs_bad | rt_bad;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wb_valid_q <= 1'b0;
      wb_rd_q    <= '0;
      wb_data_q  <= '0;
      wb_undef_q <= 1'b0;
    end else begin
      wb_valid_q <= last_step && (tag != '0);
      if (last_step) begin
        wb_rd_q    <= tag;
        wb_data_q  <= wb_ext;
        wb_undef_q <= undef_q;
      end
    end
  end

  assign issue_ready = !core_busy;
  assign busy        = core_busy;
  assign pending_rd  = tag;
  assign wb_valid    = wb_valid_q;
  assign wb_rd       = wb_rd_q;
  assign wb_data     = wb_data_q;
  assign wb_undef    = wb_undef_q & wb_valid_q;

endmodule

// File: rtl/imul_unit_checker.sv
module imul_unit_checker (
  input logic       clk,
  input logic       rst,
  input logic       issue_ready,
  input logic       busy,
  input logic [4:0] pending_rd,
  input logic       stall,
  input logic       wb_valid,
  input logic [4:0] wb_rd
);

  logic [4:0] run_cnt;

  always_ff @(posedge clk) begin
    if (rst || !busy) run_cnt <= '0;
    else              run_cnt <= run_cnt + 1'b1;
  end

  AST_WB_PULSE:      assert property (@(posedge clk) disable iff (rst) wb_valid |=> !wb_valid);                // R4
  AST_WB_AFTER_RUN:  assert property (@(posedge clk) disable iff (rst) wb_valid |-> (!busy && $past(busy)));   // R3
  AST_MAX_LATENCY:   assert property (@(posedge clk) disable iff (rst) busy |-> (run_cnt < 5'd16));            // R3
  AST_STALL_GUARD:   assert property (@(posedge clk) disable iff (rst) stall |-> (busy && pending_rd != 5'd0)); // R6
  AST_IDLE_TAG:      assert property (@(posedge clk) disable iff (rst) !busy |-> (pending_rd == 5'd0));        // R6
  AST_NO_WB_ZERO:    assert property (@(posedge clk) disable iff (rst) wb_valid |-> (wb_rd != 5'd0));          // R7
  AST_TAG_HELD:      assert property (@(posedge clk) disable iff (rst) (busy && $past(busy)) |-> $stable(pending_rd)); // R5
  AST_BUSY_REFUSES:  assert property (@(posedge clk) disable iff (rst) busy |-> !issue_ready);                 // R5
  AST_RESET_CLEAN:   assert property (@(posedge clk) $past(rst) |-> (!busy && !wb_valid && pending_rd == 5'd0)); // R8

endmodule

bind imul_unit imul_unit_checker u_chk (
  .clk         (clk),
  .rst         (rst),
  .issue_ready (issue_ready),
  .busy        (busy),
  .pending_rd  (pending_rd),
  .stall       (stall),
  .wb_valid    (wb_valid),
  .wb_rd       (wb_rd)
);

// File: tb/imul_unit_bench.sv
`timescale 1ns/1ps
module imul_unit_bench;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic        rst = 1'b1;
  logic        issue_valid = 1'b0;
  logic        issue_ready;
  logic [31:0] issue_instr = '0;
  logic [31:0] rs_v = '0, rt_v = '0;
  logic [4:0]  rd_addr_a = '0, rd_addr_b = '0;
  logic        busy, stall, wb_valid, wb_undef;
  logic [4:0]  pending_rd, wb_rd;
  logic [31:0] wb_data;

  imul_unit u_imul_unit (
    .clk(clk), .rst(rst), .issue_valid(issue_valid), .issue_ready(issue_ready),
    .issue_instr(issue_instr), .issue_rs_val(rs_v), .issue_rt_val(rt_v),
    .rd_addr_a(rd_addr_a), .rd_addr_b(rd_addr_b), .busy(busy), .pending_rd(pending_rd),
    .stall(stall), .wb_valid(wb_valid), .wb_rd(wb_rd), .wb_data(wb_data), .wb_undef(wb_undef)
  );

  logic        w_valid = 1'b0, w_ready, w_busy, w_stall, w_wb_valid, w_undef;
  logic [31:0] w_instr = '0;
  logic [63:0] w_rs = '0, w_rt = '0, w_wb_data;
  logic [4:0]  w_pending, w_wb_rd;

  imul_unit #(.XLEN(64)) u_wide (
    .clk(clk), .rst(rst), .issue_valid(w_valid), .issue_ready(w_ready),
    .issue_instr(w_instr), .issue_rs_val(w_rs), .issue_rt_val(w_rt),
    .rd_addr_a(5'd0), .rd_addr_b(5'd0), .busy(w_busy), .pending_rd(w_pending),
    .stall(w_stall), .wb_valid(w_wb_valid), .wb_rd(w_wb_rd), .wb_data(w_wb_data), .wb_undef(w_undef)
  );

  int checks = 0;
  int fails  = 0;
  bit done_flag = 0;

  localparam int NV = 12;
  localparam logic [31:0] VEC_RS [NV] = '{32'd7, 32'hfffffffd, 32'h7fffffff, 32'h80000000,
    32'd12345, 32'hffffffff, 32'h12345678, 32'hdeadbeef, 32'h80000000, 32'hffff0000,
    32'd5, 32'h0000abcd};
  localparam logic [31:0] VEC_RT [NV] = '{32'd6, 32'd5, 32'h7fffffff, 32'hffffffff,
    32'd0, 32'hffffffff, 32'h40000000, 32'd3, 32'h80000000, 32'h0001ffff,
    32'hfffffff0, 32'd1};

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mk_mul(input logic [4:0] rs, input logic [4:0] rt, input logic [4:0] rd);
    return {6'b011100, rs, rt, rd, 5'b00000, 6'b000010};
  endfunction

  // R3: smallest k with rt[31:2k-1] all equal
  function automatic int exp_lat(input logic [31:0] b);
    for (int k = 1; k <= 16; k++) begin
      bit same = 1'b1;
      for (int j = 2*k-1; j <= 31; j++) if (b[j] != b[31]) same = 1'b0;
      if (same) return k;
    end
    return 16;
  endfunction

  function automatic logic [31:0] exp_prod(input logic [31:0] a, input logic [31:0] b);
    logic signed [63:0] p;
    p = $signed(a) * $signed(b);
    return p[31:0];
  endfunction

  task automatic do_issue(input logic [31:0] ins, input logic [31:0] a, input logic [31:0] b);
    @(negedge clk);
    issue_instr = ins; rs_v = a; rt_v = b; issue_valid = 1'b1;
    @(negedge clk);
    issue_valid = 1'b0; issue_instr = '0;
  endtask

  task automatic wait_idle(output int lat, output bit saw_wb);
    lat = 0; saw_wb = 1'b0;
    while (busy && lat < 40) begin
      lat++;
      if (wb_valid) saw_wb = 1'b1;
      @(negedge clk);
    end
  endtask

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=%h expected=%h", 64'd0, 64'd1);
    finish_run();
  end

  initial begin
    int  lat;
    bit  saw;
    logic [4:0] rd;

    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R8 reset state
    chk(!busy, "R8 busy", busy, 0);
    chk(issue_ready, "R8 ready", issue_ready, 1);
    chk(pending_rd == 0, "R8 pending", pending_rd, 0);
    chk(!wb_valid && !stall, "R8 wb/stall", {wb_valid, stall}, 0);

    // Vector table: R2 product, R3 latency, R4 pulse, R6 stall
    for (int i = 0; i < NV; i++) begin
      rd = 5'(i + 1);
      do_issue(mk_mul(5'd1, 5'd2, rd), VEC_RS[i], VEC_RT[i]);
      rd_addr_a = rd; #1;
      chk(stall, "R6 stall on match", stall, 1);
      chk(pending_rd == rd, "R6 pending tag", pending_rd, rd);
      rd_addr_a = 5'd0;
      wait_idle(lat, saw);
      chk(lat == exp_lat(VEC_RT[i]), "R3 latency", lat, exp_lat(VEC_RT[i]));
      chk(wb_valid && wb_rd == rd, "R4 wb strobe/rd", {wb_valid, wb_rd}, {1'b1, rd});
      chk(wb_data == exp_prod(VEC_RS[i], VEC_RT[i]), "R2 product", wb_data, exp_prod(VEC_RS[i], VEC_RT[i]));
      @(negedge clk);
      chk(!wb_valid, "R4 single pulse", wb_valid, 0);
    end

    // R1: near-miss encodings are ignored
    begin
      logic [31:0] bad [3];
      bad[0] = {6'b011100, 5'd1, 5'd2, 5'd3, 5'b00000, 6'b000011};
      bad[1] = {6'b000000, 5'd1, 5'd2, 5'd3, 5'b00000, 6'b000010};
      bad[2] = {6'b011100, 5'd1, 5'd2, 5'd3, 5'b00001, 6'b000010};
      for (int b = 0; b < 3; b++) begin
        do_issue(bad[b], 32'd9, 32'd9);
        chk(!busy && issue_ready, "R1 no start", busy, 0);
        saw = 1'b0;
        for (int c = 0; c < 3; c++) begin
          if (wb_valid) saw = 1'b1;
          @(negedge clk);
        end
        chk(!saw, "R1 no writeback", saw, 0);
      end
    end

    // R5 / R6: refused issue during a 16-step multiply
    do_issue(mk_mul(5'd1, 5'd2, 5'd5), 32'h00001111, 32'h40000000);
    chk(!issue_ready, "R5 ready low while busy", issue_ready, 0);
    issue_instr = mk_mul(5'd3, 5'd4, 5'd9); rs_v = 32'd7; rt_v = 32'd7; issue_valid = 1'b1;
    rd_addr_b = 5'd6; #1;
    chk(!stall, "R6 no stall on mismatch", stall, 0);
    rd_addr_b = 5'd5; #1;
    chk(stall, "R6 stall on port b", stall, 1);
    @(negedge clk);
    chk(pending_rd == 5'd5, "R5 tag kept", pending_rd, 5);
    issue_valid = 1'b0; issue_instr = '0;
    wait_idle(lat, saw);
    chk(wb_valid && wb_rd == 5'd5, "R5 first rd written", wb_rd, 5);
    chk(wb_data == 32'h40000000, "R5 first product kept", wb_data, 32'h40000000);
    chk(!stall && pending_rd == 0, "R6 released after done", {stall, pending_rd}, 0);
    rd_addr_b = 5'd0;
    saw = 1'b0;
    for (int c = 0; c < 4; c++) begin
      @(negedge clk);
      if (wb_valid || busy) saw = 1'b1;
    end
    chk(!saw, "R5 refused op never ran", saw, 0);

    // R7: destination register 0
    do_issue(mk_mul(5'd1, 5'd2, 5'd0), 32'd3, 32'h40000000);
    chk(busy, "R7 still runs", busy, 1);
    rd_addr_a = 5'd0; rd_addr_b = 5'd0; #1;
    chk(!stall, "R7 no stall for r0", stall, 0);
    wait_idle(lat, saw);
    chk(lat == 16, "R7 full latency", lat, 16);
    if (wb_valid) saw = 1'b1;
    @(negedge clk);
    if (wb_valid) saw = 1'b1;
    chk(!saw, "R7 no writeback", saw, 0);

    // R8: reset abandons an in-flight multiply
    do_issue(mk_mul(5'd1, 5'd2, 5'd12), 32'd3, 32'h40000000);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk(!busy && pending_rd == 0 && issue_ready, "R8 abort clears", {busy, pending_rd}, 0);
    saw = 1'b0;
    for (int c = 0; c < 18; c++) begin
      if (wb_valid) saw = 1'b1;
      @(negedge clk);
    end
    chk(!saw, "R8 no late writeback", saw, 0);

    // R9 / R2 on the 64-bit instance
    for (int t = 0; t < 3; t++) begin
      logic [63:0] a64, b64;
      bit exp_bad;
      a64 = (t == 0) ? 64'hffff_ffff_ffff_fffe : (t == 1) ? 64'h0000_0001_0000_0005 : 64'd4;
      b64 = (t == 2) ? 64'h0000_0000_8000_0000 : 64'd3;
      exp_bad = (t != 0);
      @(negedge clk);
      w_instr = mk_mul(5'd1, 5'd2, 5'd7); w_rs = a64; w_rt = b64; w_valid = 1'b1;
      @(negedge clk);
      w_valid = 1'b0;
      lat = 0;
      while (w_busy && lat < 40) begin lat++; @(negedge clk); end
      chk(w_wb_valid && w_undef == exp_bad, "R9 word flag", w_undef, exp_bad);
      if (t == 0) chk(w_wb_data == 64'hffff_ffff_ffff_fffa, "R2 sign extension", w_wb_data, 64'hffff_ffff_ffff_fffa);
    end
    chk(!wb_undef, "R9 flag low at 32 bits", wb_undef, 0);

    repeat (2) @(negedge clk);
    finish_run();
  end

endmodule